// File: doc/BRIEF.md
# Opcode-Filtered ALU Function Selector

This block picks the 16-bit ALU operation and the flag-update rule for every microinstruction of a microcoded processor. The executing opcode selects a row, which is the set of operations that instruction may use. A 3-bit column field from the microinstruction selects one entry in that row. Because the opcode supplies the row, several opcodes can share one microcode routine: for example, an add routine and a subtract routine can both request column 1 and still get different arithmetic.

The block drives the selected function code, the carry-out source and the per-flag write enables. It also contains a small ALU with the output register and the X/N/Z/V/C flag register behind it. Its last output is the value written to a data-section destination. In byte mode only the low byte of that destination is replaced. The full opcode decode is represented here by a compact stub table.

Top module: `alu_func_select`

## Requirements
- R1: The row is opcode[15:12]; line value 15 behaves as row 0. Column 1 of each row is listed below as (operation, B complemented, carry-in, carry source, flag set on first, flag set on last). The flag sets are written as letters and are described in R5.
  - 0: OR, no, 0, 4, none, none
  - 1: ADD, no, 0, 0, XNZVC, NZ
  - 2: ADD, yes, 1, 1, XNZVC, NZ
  - 3: ADD, yes, 1, 1, NZVC, NZ
  - 4: ADD, no, X, 0, XNZVC, NZ
  - 5: ADD, yes, ~X, 1, XNZVC, NZ
  - 6: AND, no, -, 4, NZVC, none
  - 7: OR, no, -, 4, NZVC, none
  - 8: AND, yes, -, 4, NZVC, none
  - 9: ADD, no, 0, 4, none, none
  - 10: OR, yes, -, 4, NZVC, none
  - 11: SEXT, no, -, 4, NZVC, none
  - 12: SHR, no, -, 3, XNZVC, none
  - 13: ADD, no, 1, 0, XNZVC, NZ
  - 14: OR, no, -, 2, C, none
- R2: The columns below are the same in every row. None of them complements B.
  - Column 2: A+B with carry-in 0, carry source 4, no flag enables.
  - Column 3: A AND B, carry source 4, enables N and Z.
  - Column 4: logical right shift of A by one with 0 shifted in, carry source 3, enables N, Z and C.
  - Column 5: sign extension of B's low byte, carry source 4, enables N and Z.
- R3: Column codes 0 and 7 raise `hold`. During hold, `alu_q` and `flags` keep their values at the next edge, `flag_we` is 0, `alu_func` reads 0 and `carry_src` reads 4.
- R4: Column 6 equals column 4 except that a 1 is shifted into bit 15.
- R5: Column 1 takes its first flag set when `ucyc_first` is 1, otherwise its second set when `ucyc_last` is 1, otherwise no enables. Columns 2 to 6 ignore both bits. `flag_we` bits are [4]=X, [3]=N, [2]=Z, [1]=V, [0]=C.
- R6: At a rising edge without hold, only enabled flags change. The flag values are:
  - N is result bit 15.
  - Z is set when the result is zero.
  - V is the signed overflow of an ADD operation and 0 for every other operation.
  - C is the selected carry-out value, and X takes the same value as C.
- R7: `carry_src` encodings:
  - 0: adder carry
  - 1: inverted adder carry
  - 2: result bit 15
  - 3: `a_in` bit 0
  - 4: constant 0
- R8: Byte mode is opcode[7:6]==00. In byte mode, `byte_we`=01 and `dst_out` is {dst_in[15:8], alu_q[7:0]}. Otherwise `byte_we`=11 and `dst_out`=`alu_q`.
- R9: Subtraction is A + ~B + 1. The `alu_func` encodings are:
  - 0: ADD
  - 1: AND
  - 2: OR
  - 3: SEXT
  - 4: SHR
  Rows 1 and 2 share column 1 but give different results.
- R10: While `rst_n` is low, `alu_q` and `flags` are zero.
- R11: `alu_q` and `flags` load at the rising edge when hold is low. The X carry-in uses the registered X flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 16 | Executing opcode word |
| col_sel | input | 3 | Column code from the microinstruction |
| ucyc_first | input | 1 | Initiate mark for column 1 flag control |
| ucyc_last | input | 1 | Finish mark for column 1 flag control |
| a_in | input | 16 | A operand, address-bus side |
| b_in | input | 16 | B operand |
| dst_in | input | 16 | Current destination value |
| hold | output | 1 | Idle column selected |
| alu_func | output | 3 | Selected operation code |
| carry_src | output | 3 | Selected carry-out source |
| flag_we | output | 5 | Flag write enables X,N,Z,V,C |
| byte_we | output | 2 | Destination byte write mask |
| alu_q | output | 16 | ALU output register |
| flags | output | 5 | Flag register X,N,Z,V,C |
| dst_out | output | 16 | Value written to the destination |

## Verification
The assertions assume that the opcode and column are stable across each rising edge. They also assume that `ucyc_first` and `ucyc_last` are ordinary 0/1 levels and that any 3-bit column code, including the unused code 7, may arrive. The stimulus drives every input at the falling edge and keeps it constant through the next rising edge. A random phase covers all sixteen opcode lines, all eight column codes and both size encodings, so every row, the hold codes and both byte-mode states are reached.

// File: rtl/alu_sel_pkg.sv
`timescale 1ns/1ps
package alu_sel_pkg;

  localparam int NUM_ROWS = 15;
  localparam int NFLAG    = 5;

  typedef enum logic [2:0] {OP_ADD = 3'd0, OP_AND = 3'd1, OP_OR = 3'd2,
                            OP_SEXT = 3'd3, OP_SHR = 3'd4} alu_op_e;

  typedef enum logic [2:0] {CS_CARRY = 3'd0, CS_NCARRY = 3'd1, CS_MSB = 3'd2,
                            CS_AB0 = 3'd3, CS_ZERO = 3'd4} cout_src_e;

  typedef enum logic [1:0] {CI_ZERO = 2'd0, CI_ONE = 2'd1, CI_X = 2'd2,
                            CI_NX = 2'd3} cin_e;

  // flag bit order: X N Z V C
  localparam logic [NFLAG-1:0] F_NONE = 5'b00000;
  localparam logic [NFLAG-1:0] F_ALL  = 5'b11111;
  localparam logic [NFLAG-1:0] F_NZVC = 5'b01111;
  localparam logic [NFLAG-1:0] F_NZC  = 5'b01101;
  localparam logic [NFLAG-1:0] F_NZ   = 5'b01100;
  localparam logic [NFLAG-1:0] F_C    = 5'b00001;

  typedef struct packed {
    alu_op_e   op;
    logic      inv_b;
    cin_e      cin;
    cout_src_e csrc;
    logic      shin;
  } alu_ctrl_t;

  typedef struct packed {
    alu_ctrl_t        ctrl;
    logic [NFLAG-1:0] set_first;
    logic [NFLAG-1:0] set_last;
  } row_ent_t;

  function automatic row_ent_t mk_row(alu_op_e op, logic inv, cin_e ci,
                                      cout_src_e cs, logic [NFLAG-1:0] fa,
                                      logic [NFLAG-1:0] fb);
    row_ent_t e;
    e.ctrl.op    = op;
    e.ctrl.inv_b = inv;
    e.ctrl.cin   = ci;
    e.ctrl.csrc  = cs;
    e.ctrl.shin  = 1'b0;
    e.set_first  = fa;
    e.set_last   = fb;
    return e;
  endfunction

  // column-1 entry of each row (stub opcode decode)
  function automatic row_ent_t row_entry(input logic [3:0] row);
    case (row)
      4'd1:    return mk_row(OP_ADD,  1'b0, CI_ZERO, CS_CARRY,  F_ALL,  F_NZ);
      4'd2:    return mk_row(OP_ADD,  1'b1, CI_ONE,  CS_NCARRY, F_ALL,  F_NZ);
      4'd3:    return mk_row(OP_ADD,  1'b1, CI_ONE,  CS_NCARRY, F_NZVC, F_NZ);
      4'd4:    return mk_row(OP_ADD,  1'b0, CI_X,    CS_CARRY,  F_ALL,  F_NZ);
      4'd5:    return mk_row(OP_ADD,  1'b1, CI_NX,   CS_NCARRY, F_ALL,  F_NZ);
      4'd6:    return mk_row(OP_AND,  1'b0, CI_ZERO, CS_ZERO,   F_NZVC, F_NONE);
      4'd7:    return mk_row(OP_OR,   1'b0, CI_ZERO, CS_ZERO,   F_NZVC, F_NONE);
      4'd8:    return mk_row(OP_AND,  1'b1, CI_ZERO, CS_ZERO,   F_NZVC, F_NONE);
      4'd9:    return mk_row(OP_ADD,  1'b0, CI_ZERO, CS_ZERO,   F_NONE, F_NONE);
      4'd10:   return mk_row(OP_OR,   1'b1, CI_ZERO, CS_ZERO,   F_NZVC, F_NONE);
      4'd11:   return mk_row(OP_SEXT, 1'b0, CI_ZERO, CS_ZERO,   F_NZVC, F_NONE);
      4'd12:   return mk_row(OP_SHR,  1'b0, CI_ZERO, CS_AB0,    F_ALL,  F_NONE);
      4'd13:   return mk_row(OP_ADD,  1'b0, CI_ONE,  CS_CARRY,  F_ALL,  F_NZ);
      4'd14:   return mk_row(OP_OR,   1'b0, CI_ZERO, CS_MSB,    F_C,    F_NONE);
      default: return mk_row(OP_OR,   1'b0, CI_ZERO, CS_ZERO,   F_NONE, F_NONE);
    endcase
  endfunction

endpackage

// File: rtl/alu_sel_decode.sv
`timescale 1ns/1ps
module alu_sel_decode
  import alu_sel_pkg::*;
#(
  parameter int OPC_W    = 16,
  parameter int COL_W    = 3,
  parameter int SIZE_LSB = 6
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [COL_W-1:0] col_sel,
  input  logic             ucyc_first,
  input  logic             ucyc_last,
  output alu_ctrl_t        ctrl,
  output logic [NFLAG-1:0] flag_we,
  output logic             hold,
  output logic             byte_mode
);

  localparam int LINE_W = 4;

  logic [LINE_W-1:0] line_raw;
  logic [LINE_W-1:0] row;
  row_ent_t          ent;

  assign line_raw  = opcode[OPC_W-1 -: LINE_W];
  assign row       = (line_raw == LINE_W'(NUM_ROWS)) ? '0 : line_raw;
  assign byte_mode = (opcode[SIZE_LSB +: 2] == 2'b00);

  always_comb begin
    ent          = row_entry(row);
    ctrl.op      = OP_ADD;
    ctrl.inv_b   = 1'b0;
    ctrl.cin     = CI_ZERO;
    ctrl.csrc    = CS_ZERO;
    ctrl.shin    = 1'b0;
    flag_we      = F_NONE;
    hold         = 1'b0;
    case (col_sel)
      COL_W'(1): begin
        ctrl = ent.ctrl;
        if (ucyc_first)     flag_we = ent.set_first;
        else if (ucyc_last) flag_we = ent.set_last;
      end
      COL_W'(2): ctrl.op = OP_ADD;
      COL_W'(3): begin
        ctrl.op = OP_AND;
        flag_we = F_NZ;
      end
      COL_W'(4), COL_W'(6): begin
        ctrl.op   = OP_SHR;
        ctrl.csrc = CS_AB0;
        ctrl.shin = (col_sel == COL_W'(6));
        flag_we   = F_NZC;
      end
      COL_W'(5): begin
        ctrl.op = OP_SEXT;
        flag_we = F_NZ;
      end
      default: hold = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_sel_core.sv
`timescale 1ns/1ps
module alu_sel_core
  import alu_sel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  alu_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              x_in,
  output logic [DATA_W-1:0] res,
  output logic [NFLAG-1:0]  flag_val
);

  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add_w(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y,
                                            input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  function automatic logic [DATA_W-1:0] sext_byte(input logic [DATA_W-1:0] x);
    return {{(DATA_W-BYTE_W){x[BYTE_W-1]}}, x[BYTE_W-1:0]};
  endfunction

  logic [DATA_W-1:0] bb;
  logic              cin_v;
  logic [DATA_W:0]   sum;
  logic              carry;
  logic              ovf;
  logic              cout;

  always_comb begin
    bb = ctrl.inv_b ? ~b_in : b_in;
    case (ctrl.cin)
      CI_ONE:  cin_v = 1'b1;
      CI_X:    cin_v = x_in;
      CI_NX:   cin_v = ~x_in;
      default: cin_v = 1'b0;
    endcase
    sum   = add_w(a_in, bb, cin_v);
    carry = sum[DATA_W];
    case (ctrl.op)
      OP_AND:  res = a_in & bb;
      OP_OR:   res = a_in | bb;
      OP_SEXT: res = sext_byte(bb);
      OP_SHR:  res = {ctrl.shin, a_in[MSB:1]};
      default: res = sum[MSB:0];
    endcase
    ovf = (ctrl.op == OP_ADD) && (a_in[MSB] == bb[MSB]) && (res[MSB] != a_in[MSB]);
    case (ctrl.csrc)
      CS_CARRY:  cout = carry;
      CS_NCARRY: cout = ~carry;
      CS_MSB:    cout = res[MSB];
      CS_AB0:    cout = a_in[0];
      default:   cout = 1'b0;
    endcase
    flag_val = {cout, res[MSB], (res == '0), ovf, cout};
  end

  // R4: the shifter fills bit MSB with the requested shift-in value
  a_r4_shift_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.op == OP_SHR) |-> (res[MSB] == ctrl.shin));

  // R6: overflow is only reported by the adder
  a_r6_logic_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.op != OP_ADD) |-> !flag_val[1]);

  // R9: a plain subtract reports a borrow exactly when A < B unsigned
  a_r9_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.op == OP_ADD && ctrl.inv_b && ctrl.cin == CI_ONE && ctrl.csrc == CS_NCARRY)
      |-> (flag_val[0] == (a_in < b_in)));

endmodule

// File: rtl/alu_func_select.sv
`timescale 1ns/1ps
module alu_func_select
  import alu_sel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       opcode,
  input  logic [COL_W-1:0]  col_sel,
  input  logic              ucyc_first,
  input  logic              ucyc_last,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] dst_in,
  output logic              hold,
  output logic [2:0]        alu_func,
  output logic [2:0]        carry_src,
  output logic [NFLAG-1:0]  flag_we,
  output logic [DATA_W/BYTE_W-1:0] byte_we,
  output logic [DATA_W-1:0] alu_q,
  output logic [NFLAG-1:0]  flags,
  output logic [DATA_W-1:0] dst_out
);

  localparam int NBYTE = DATA_W / BYTE_W;
  localparam int X_BIT = NFLAG - 1;

  alu_ctrl_t         ctrl;
  logic              byte_mode;
  logic [DATA_W-1:0] res;
  logic [NFLAG-1:0]  flag_val;

  alu_sel_decode #(.OPC_W(16), .COL_W(COL_W), .SIZE_LSB(6)) u_dec (
    .opcode     (opcode),
    .col_sel    (col_sel),
    .ucyc_first (ucyc_first),
    .ucyc_last  (ucyc_last),
    .ctrl       (ctrl),
    .flag_we    (flag_we),
    .hold       (hold),
    .byte_mode  (byte_mode)
  );

  alu_sel_core #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .a_in     (a_in),
    .b_in     (b_in),
    .x_in     (flags[X_BIT]),
    .res      (res),
    .flag_val (flag_val)
  );

  assign alu_func  = ctrl.op;
  assign carry_src = ctrl.csrc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_q <= '0;
      flags <= '0;
    end else if (!hold) begin
      alu_q <= res;
      flags <= (flags & ~flag_we) | (flag_val & flag_we);
    end
  end

  // byte lanes: lane 0 always written, upper lanes only outside byte mode
  for (genvar gi = 0; gi < NBYTE; gi++) begin : g_lane
    if (gi == 0) begin : g_low
      assign byte_we[gi] = 1'b1;
      assign dst_out[gi*BYTE_W +: BYTE_W] = alu_q[gi*BYTE_W +: BYTE_W];
    end else begin : g_high
      assign byte_we[gi] = ~byte_mode;
      assign dst_out[gi*BYTE_W +: BYTE_W] = byte_mode ? dst_in[gi*BYTE_W +: BYTE_W]
                                                      : alu_q[gi*BYTE_W +: BYTE_W];
    end
  end

  // R3: an idle column leaves the output and flag registers untouched
  a_r3_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(alu_q) && $stable(flags)));

  // R6: a flag changes only where its enable was raised in the cycle before
  a_r6_flag_we_gates: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(flag_we)) == '0));

endmodule

// File: tb/alu_func_select_tb.sv
`timescale 1ns/1ps
module alu_func_select_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opcode = '0;
  logic [2:0]  col_sel = '0;
  logic        ucyc_first = 1'b0;
  logic        ucyc_last = 1'b0;
  logic [15:0] a_in = '0, b_in = '0, dst_in = '0;
  logic        hold;
  logic [2:0]  alu_func, carry_src;
  logic [4:0]  flag_we, flags;
  logic [1:0]  byte_we;
  logic [15:0] alu_q, dst_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [15:0] m_q = '0;
  logic [4:0]  m_flags = '0;

  always #2 clk = ~clk;

  alu_func_select dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .col_sel(col_sel),
    .ucyc_first(ucyc_first), .ucyc_last(ucyc_last), .a_in(a_in), .b_in(b_in),
    .dst_in(dst_in), .hold(hold), .alu_func(alu_func), .carry_src(carry_src),
    .flag_we(flag_we), .byte_we(byte_we), .alu_q(alu_q), .flags(flags),
    .dst_out(dst_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // column-1 behaviour per row: op, invert, cin(0 zero,1 one,2 X,3 notX), carry src, sets
  task automatic row_model(input int row, output int op, output int inv, output int ci,
                           output int cs, output int fa, output int fb);
    op = 2; inv = 0; ci = 0; cs = 4; fa = 0; fb = 0;
    case (row)
      1:  begin op = 0; cs = 0; fa = 'h1F; fb = 'h0C; end
      2:  begin op = 0; inv = 1; ci = 1; cs = 1; fa = 'h1F; fb = 'h0C; end
      3:  begin op = 0; inv = 1; ci = 1; cs = 1; fa = 'h0F; fb = 'h0C; end
      4:  begin op = 0; ci = 2; cs = 0; fa = 'h1F; fb = 'h0C; end
      5:  begin op = 0; inv = 1; ci = 3; cs = 1; fa = 'h1F; fb = 'h0C; end
      6:  begin op = 1; fa = 'h0F; end
      7:  begin op = 2; fa = 'h0F; end
      8:  begin op = 1; inv = 1; fa = 'h0F; end
      9:  begin op = 0; end
      10: begin op = 2; inv = 1; fa = 'h0F; end
      11: begin op = 3; fa = 'h0F; end
      12: begin op = 4; cs = 3; fa = 'h1F; end
      13: begin op = 0; ci = 1; cs = 0; fa = 'h1F; fb = 'h0C; end
      14: begin op = 2; cs = 2; fa = 'h01; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [15:0] opc, input int c, input logic f, input logic l,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] d);
    int row, op, inv, ci, cs, fa, fb, we, shin, e_hold, cinv, carry, vflag, cflag;
    logic [15:0] bv, r;
    logic [16:0] s;
    @(negedge clk);
    opcode = opc; col_sel = c[2:0]; ucyc_first = f; ucyc_last = l;
    a_in = a; b_in = b; dst_in = d;
    #1;
    row = int'(opc[15:12]);
    if (row == 15) row = 0;
    e_hold = 0; shin = 0; op = 0; inv = 0; ci = 0; cs = 4; we = 0;
    case (c)
      1: begin
        row_model(row, op, inv, ci, cs, fa, fb);
        we = f ? fa : (l ? fb : 0);
      end
      2: begin op = 0; end
      3: begin op = 1; we = 'h0C; end
      4: begin op = 4; cs = 3; we = 'h0D; end
      6: begin op = 4; cs = 3; we = 'h0D; shin = 1; end
      5: begin op = 3; we = 'h0C; end
      default: e_hold = 1;
    endcase
    chk("R3", "hold", int'(hold), e_hold);
    chk("R9", "alu_func", int'(alu_func), op);
    chk("R7", "carry_src", int'(carry_src), cs);
    chk("R5", "flag_we", int'(flag_we), we);
    chk("R8", "byte_we", int'(byte_we), (opc[7:6] == 2'b00) ? 1 : 3);
    // reference arithmetic
    bv = inv ? ~b : b;
    cinv = (ci == 1) ? 1 : (ci == 2) ? int'(m_flags[4]) : (ci == 3) ? 1 - int'(m_flags[4]) : 0;
    s = 17'(a) + 17'(bv) + 17'(cinv);
    carry = int'(s[16]);
    case (op)
      1: r = a & bv;
      2: r = a | bv;
      3: r = bv[7] ? (16'hFF00 | {8'h00, bv[7:0]}) : {8'h00, bv[7:0]};
      4: r = (a >> 1) | (shin ? 16'h8000 : 16'h0000);
      default: r = s[15:0];
    endcase
    vflag = (op == 0 && a[15] == bv[15] && r[15] != a[15]) ? 1 : 0;
    case (cs)
      0: cflag = carry;
      1: cflag = 1 - carry;
      2: cflag = int'(r[15]);
      3: cflag = int'(a[0]);
      default: cflag = 0;
    endcase
    @(posedge clk);
    #1;
    if (!e_hold) begin
      logic [4:0] v, w;
      v = {cflag[0], r[15], (r == 16'h0), vflag[0], cflag[0]};
      w = we[4:0];
      m_q = r;
      m_flags = (m_flags & ~w) | (v & w);
    end
    chk("R11", "alu_q", int'(alu_q), int'(m_q));
    chk("R6", "flags", int'(flags), int'(m_flags));
    chk("R8", "dst_out", int'(dst_out),
        int'((opc[7:6] == 2'b00) ? {d[15:8], m_q[7:0]} : m_q));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "alu_q in reset", int'(alu_q), 0);
    chk("R10", "flags in reset", int'(flags), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R6: add with signed overflow
    step(16'h1040, 1, 1, 0, 16'h7FFF, 16'h0001, 16'h0);
    chk("R1", "add result", int'(alu_q), 'h8000);
    chk("R6", "add flags", int'(flags), 'b01010);
    // R9: same column in the subtract row gives a different result
    step(16'h2040, 1, 1, 0, 16'h7FFF, 16'h0001, 16'h0);
    chk("R9", "sub result", int'(alu_q), 'h7FFE);
    step(16'h2040, 1, 1, 0, 16'h0000, 16'h0001, 16'h0);
    chk("R9", "sub borrow result", int'(alu_q), 'hFFFF);
    chk("R7", "sub borrow flags", int'(flags), 'b11001);
    // R11: extended add picks up the registered X
    step(16'h4040, 1, 1, 0, 16'h0001, 16'h0001, 16'h0);
    chk("R11", "addx result", int'(alu_q), 3);
    // R3: idle codes
    step(16'h1040, 0, 1, 0, 16'h1234, 16'h1111, 16'h0);
    chk("R3", "col0 keeps q", int'(alu_q), 3);
    step(16'h1040, 7, 1, 1, 16'h1234, 16'h1111, 16'h0);
    chk("R3", "col7 keeps q", int'(alu_q), 3);
    // R5: finish set, no mark, marks on other columns
    step(16'h1040, 1, 0, 1, 16'h0000, 16'h0000, 16'h0);
    step(16'h1040, 1, 0, 0, 16'h8000, 16'h8000, 16'h0);
    step(16'h1040, 3, 1, 0, 16'h00F0, 16'h0F0F, 16'h0);
    step(16'h1040, 3, 0, 1, 16'h00F0, 16'h0F0F, 16'h0);
    // R2 R4: shifts
    step(16'h0040, 4, 0, 0, 16'h0003, 16'h0, 16'h0);
    chk("R2", "shift zero fill", int'(alu_q), 'h0001);
    step(16'h0040, 6, 0, 0, 16'h0003, 16'h0, 16'h0);
    chk("R4", "shift one fill", int'(alu_q), 'h8001);
    // R2: sign extension
    step(16'h0040, 5, 0, 0, 16'h0, 16'h0080, 16'h0);
    chk("R2", "sext", int'(alu_q), 'hFF80);
    // R8: byte mode merge
    step(16'h1000, 2, 0, 0, 16'h0012, 16'h0034, 16'hAB00);
    chk("R8", "byte merge", int'(dst_out), 'hAB46);
    // R1: line 15 behaves as row 0
    step(16'hF040, 1, 1, 0, 16'h0005, 16'h0003, 16'h0);
    chk("R1", "line15 row0", int'(alu_q), 7);
    // R6 random coverage
    for (int i = 0; i < 600; i++) begin
      step(16'($urandom), int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
           16'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule